// File: doc/BRIEF.md
# Four-Phase Asynchronous Bus Handshake Node

This block holds a bus master and a bus slave that talk over a request/acknowledge pair with no shared clock. Every step waits for the other side's edge. For a write, the master places the address, the direction and the write data on its bus outputs. It holds them for a set number of local cycles so that slaves can decode the target. It then raises request. The slave stores the data and raises acknowledge. The master drops request, and the slave drops acknowledge in turn. A read runs the same four phases. The only difference is that the slave presents its read word together with acknowledge, and the master takes that word in the cycle it lowers request.

Each side samples the other side's handshake wire through a two-flop synchronizer running on its own local clock. Master and slave are separate port groups, so a system can wire one node's master to another node's slave, or loop a node back onto itself. The slave owns a small word store at an aligned base address. It does not answer any request outside that window.

Top module: `hs4_node`

## Requirements
- R1: After reset, m_req and s_ack are low, cmd_idle is high and cmd_done is low.
- R2: When cmd_go is sampled high while cmd_idle is high, m_addr, m_we and m_wdata take the command in that same edge. m_req then rises exactly SETTLE clock edges later (default 2), so SETTLE local samples show the new address with m_req still low.
- R3: A write request (m_we = 1) to an address whose upper bits AW-1..LW equal those of BASE stores s_wdata in word s_addr[LW-1:0] and raises s_ack.
- R4: On a read request (m_we = 0), the slave drives the addressed word on s_rdata before or with s_ack and holds it while s_ack stays high. The master places the word on cmd_rdata as it drops m_req.
- R5: The master lowers m_req only after it has seen s_ack high. The slave lowers s_ack only after it has seen s_req low.
- R6: m_addr, m_we and m_wdata stay stable while m_req is high. A cmd_go that arrives while cmd_idle is low is ignored, so the bus fields do not change and the running transfer completes with its own data.
- R7: A request whose upper address bits do not match BASE never raises s_ack, and the stored words do not change.
- R8: When the master sees s_ack low after dropping m_req, cmd_done is high for exactly one cycle and cmd_idle is high from that same cycle.
- R9: s_ack rises on the third clock edge after s_req rises, and falls on the third edge after s_req falls: two synchronizer stages plus one register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local sampling clock |
| rst_n | input | 1 | Active-low reset |
| cmd_go | input | 1 | Start a transfer (taken only when idle) |
| cmd_we | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | AW | Transfer address |
| cmd_wdata | input | DW | Write data |
| cmd_idle | output | 1 | Master ready for a new command |
| cmd_done | output | 1 | One-cycle completion pulse |
| cmd_rdata | output | DW | Last read word |
| m_req | output | 1 | Master request wire |
| m_we | output | 1 | Master direction wire |
| m_addr | output | AW | Master address wires |
| m_wdata | output | DW | Master write-data wires |
| m_ack | input | 1 | Acknowledge seen by master (asynchronous) |
| m_rdata | input | DW | Read data seen by master |
| s_req | input | 1 | Request seen by slave (asynchronous) |
| s_we | input | 1 | Direction seen by slave |
| s_addr | input | AW | Address seen by slave |
| s_wdata | input | DW | Write data seen by slave |
| s_ack | output | 1 | Slave acknowledge wire |
| s_rdata | output | DW | Slave read-data wires |

## Verification
The assertions assume that the slave-side address, direction and write data do not move while s_req is high. They also assume that whoever drives s_req lowers it only after s_ack has risen, or after a miss has been given up. The bench loops the master back onto the slave for random and directed transfers, restricted to addresses inside the slave window. It drives the slave ports directly only for the miss and latency cases, and in those cases it holds every field steady from before the request until after the request falls.

// File: rtl/hs4_node.sv
module hs4_node #(
  parameter int AW = 8,
  parameter int DW = 16,
  parameter int WORDS = 4,
  parameter int SETTLE = 2,
  parameter logic [AW-1:0] BASE = 8'h40
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_go,
  input  logic          cmd_we,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_wdata,
  output logic          cmd_idle,
  output logic          cmd_done,
  output logic [DW-1:0] cmd_rdata,
  output logic          m_req,
  output logic          m_we,
  output logic [AW-1:0] m_addr,
  output logic [DW-1:0] m_wdata,
  input  logic          m_ack,
  input  logic [DW-1:0] m_rdata,
  input  logic          s_req,
  input  logic          s_we,
  input  logic [AW-1:0] s_addr,
  input  logic [DW-1:0] s_wdata,
  output logic          s_ack,
  output logic [DW-1:0] s_rdata
);
  localparam int LW = $clog2(WORDS);
  localparam int CW = $clog2(SETTLE + 1);

  typedef enum logic [1:0] {M_IDLE, M_SETTLE, M_HOLD, M_REL} mst_t;
  mst_t mst;
  logic [CW-1:0] settle_cnt;
  logic [1:0] ack_sync, req_sync;
  logic ack_s, req_s;
  logic [DW-1:0] mem [WORDS];
  logic s_hit;

  assign ack_s    = ack_sync[1];
  assign req_s    = req_sync[1];
  assign cmd_idle = (mst == M_IDLE);
  assign s_hit    = (s_addr[AW-1:LW] == BASE[AW-1:LW]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_sync <= '0;
      req_sync <= '0;
    end else begin
      ack_sync <= {ack_sync[0], m_ack};
      req_sync <= {req_sync[0], s_req};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mst        <= M_IDLE;
      settle_cnt <= '0;
      m_req      <= 1'b0;
      m_we       <= 1'b0;
      m_addr     <= '0;
      m_wdata    <= '0;
      cmd_done   <= 1'b0;
      cmd_rdata  <= '0;
    end else begin
      cmd_done <= 1'b0;
      case (mst)
        M_IDLE: if (cmd_go) begin
          m_we       <= cmd_we;
          m_addr     <= cmd_addr;
          m_wdata    <= cmd_wdata;
          settle_cnt <= '0;
          mst        <= M_SETTLE;
        end
        M_SETTLE: begin
          if (settle_cnt == CW'(SETTLE - 1)) begin
            m_req <= 1'b1;
            mst   <= M_HOLD;
          end else begin
            settle_cnt <= settle_cnt + 1'b1;
          end
        end
        M_HOLD: if (ack_s) begin
          m_req <= 1'b0;
          if (!m_we) cmd_rdata <= m_rdata;
          mst <= M_REL;
        end
        M_REL: if (!ack_s) begin
          cmd_done <= 1'b1;
          mst      <= M_IDLE;
        end
        default: mst <= M_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_ack   <= 1'b0;
      s_rdata <= '0;
      for (int i = 0; i < WORDS; i++) mem[i] <= '0;
    end else if (!s_ack) begin
      if (req_s && s_hit) begin
        if (s_we) mem[s_addr[LW-1:0]] <= s_wdata;
        else      s_rdata <= mem[s_addr[LW-1:0]];
        s_ack <= 1'b1;
      end
    end else if (!req_s) begin
      s_ack <= 1'b0;
    end
  end

  // R5
  req_drop_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(m_req) |-> $past(ack_s));
  // R5
  ack_drop_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(s_ack) |-> !$past(req_s));
  // R7
  no_ack_on_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(s_ack) |-> $past(s_hit) && $past(req_s));
  // R6
  bus_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_req && $past(m_req) |-> $stable(m_addr) && $stable(m_we) && $stable(m_wdata));
  // R2
  settle_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(m_req) |-> $stable(m_addr) && $stable(m_we));
  // R4
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_ack && $past(s_ack) |-> $stable(s_rdata));
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done |=> !cmd_done);
endmodule

// File: tb/hs4_node_tb.sv
module hs4_node_tb;
  localparam int AW = 8, DW = 16, WORDS = 4, SETTLE = 2;
  localparam logic [AW-1:0] BASE = 8'h40;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_go = 1'b0, cmd_we = 1'b0;
  logic [AW-1:0] cmd_addr = '0;
  logic [DW-1:0] cmd_wdata = '0;
  logic cmd_idle, cmd_done;
  logic [DW-1:0] cmd_rdata;
  logic m_req, m_we, s_ack;
  logic [AW-1:0] m_addr;
  logic [DW-1:0] m_wdata, s_rdata;
  logic direct = 1'b0, d_req = 1'b0, d_we = 1'b0;
  logic [AW-1:0] d_addr = '0;
  logic [DW-1:0] d_wdata = '0;
  logic s_req_w, s_we_w;
  logic [AW-1:0] s_addr_w;
  logic [DW-1:0] s_wdata_w;

  int checks = 0, fails = 0;
  logic [DW-1:0] model [WORDS];
  logic prev_req = 1'b0, prev_ack = 1'b0;

  assign s_req_w   = direct ? d_req   : m_req;
  assign s_we_w    = direct ? d_we    : m_we;
  assign s_addr_w  = direct ? d_addr  : m_addr;
  assign s_wdata_w = direct ? d_wdata : m_wdata;

  always #2.5 clk = ~clk;

  hs4_node #(.AW(AW), .DW(DW), .WORDS(WORDS), .SETTLE(SETTLE), .BASE(BASE)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_go(cmd_go), .cmd_we(cmd_we), .cmd_addr(cmd_addr),
    .cmd_wdata(cmd_wdata), .cmd_idle(cmd_idle), .cmd_done(cmd_done), .cmd_rdata(cmd_rdata),
    .m_req(m_req), .m_we(m_we), .m_addr(m_addr), .m_wdata(m_wdata), .m_ack(s_ack),
    .m_rdata(s_rdata), .s_req(s_req_w), .s_we(s_we_w), .s_addr(s_addr_w),
    .s_wdata(s_wdata_w), .s_ack(s_ack), .s_rdata(s_rdata));

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] win_addr(input int idx);
    return BASE + AW'(idx);
  endfunction

  // R5: interlock seen at the wires
  always @(negedge clk) if (rst_n && !direct) begin
    if (prev_req && !m_req) check(prev_ack, "R5 req fell without ack", 32'(prev_ack), 1);
    if (prev_ack && !s_ack) check(!prev_req, "R5 ack fell while req high", 32'(prev_req), 0);
    prev_req = m_req;
    prev_ack = s_ack;
  end

  task automatic do_op(input bit we, input int idx, input logic [DW-1:0] wd, input bit poke);
    int n;
    @(negedge clk);
    cmd_go = 1'b1; cmd_we = we; cmd_addr = win_addr(idx); cmd_wdata = wd;
    @(negedge clk);
    cmd_go = 1'b0;
    check(m_addr == win_addr(idx) && m_we == we, "R2 bus fields", 32'(m_addr), 32'(win_addr(idx)));
    n = 0;
    while (!m_req && n < 50) begin n++; @(negedge clk); end
    check(n == SETTLE, "R2 settle cycles", n, SETTLE);
    if (poke) begin
      cmd_go = 1'b1; cmd_we = ~we; cmd_addr = win_addr((idx + 1) % WORDS); cmd_wdata = ~wd;
      @(negedge clk);
      cmd_go = 1'b0;
      @(negedge clk);
      check(m_addr == win_addr(idx) && m_we == we && m_wdata == wd, "R6 busy go ignored",
            32'(m_addr), 32'(win_addr(idx)));
    end
    n = 0;
    while (!cmd_done && n < 100) begin n++; @(negedge clk); end
    check(cmd_done && cmd_idle, "R8 done with idle", 32'({cmd_done, cmd_idle}), 3);
    if (we) model[idx] = wd;
    else check(cmd_rdata == model[idx], "R4 read data", 32'(cmd_rdata), 32'(model[idx]));
    @(negedge clk);
    check(!cmd_done && cmd_idle, "R8 single pulse", 32'(cmd_done), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < WORDS; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    check(!m_req && !s_ack && cmd_idle && !cmd_done, "R1 reset state",
          32'({m_req, s_ack, cmd_idle, cmd_done}), 32'b0010);
    rst_n = 1'b1;
    @(negedge clk);
    check(!m_req && !s_ack && cmd_idle, "R1 after release", 32'({m_req, s_ack, cmd_idle}), 1);

    // R3 write then R4 read back
    do_op(1'b1, 0, 16'hA5C3, 1'b0);
    do_op(1'b0, 0, '0, 1'b0);
    do_op(1'b1, WORDS - 1, 16'hFFFF, 1'b0);
    do_op(1'b0, WORDS - 1, '0, 1'b0);
    // R6 go while busy
    do_op(1'b1, 1, 16'h1234, 1'b1);
    do_op(1'b0, 1, '0, 1'b1);
    do_op(1'b0, 2, '0, 1'b0);

    // R9 latency and R3 direct write
    @(negedge clk);
    direct = 1'b1; d_we = 1'b1; d_addr = win_addr(2); d_wdata = 16'h0BEE; d_req = 1'b1;
    @(negedge clk); check(!s_ack, "R9 ack edge1", 32'(s_ack), 0);
    @(negedge clk); check(!s_ack, "R9 ack edge2", 32'(s_ack), 0);
    @(negedge clk); check(s_ack, "R9 ack edge3", 32'(s_ack), 1);
    model[2] = 16'h0BEE;
    d_req = 1'b0;
    @(negedge clk); check(s_ack, "R9 hold edge1", 32'(s_ack), 1);
    @(negedge clk); check(s_ack, "R9 hold edge2", 32'(s_ack), 1);
    @(negedge clk); check(!s_ack, "R9 fall edge3", 32'(s_ack), 0);

    // R7 miss write and miss read
    d_we = 1'b1; d_addr = BASE ^ 8'h80; d_wdata = 16'hDEAD;
    @(negedge clk);
    d_req = 1'b1;
    begin
      bit seen = 1'b0;
      for (int k = 0; k < 12; k++) begin @(negedge clk); if (s_ack) seen = 1'b1; end
      check(!seen, "R7 no ack on miss write", 32'(seen), 0);
    end
    d_req = 1'b0;
    repeat (3) @(negedge clk);
    d_we = 1'b0; d_addr = BASE + 8'h04;
    @(negedge clk);
    d_req = 1'b1;
    begin
      bit seen = 1'b0;
      for (int k = 0; k < 12; k++) begin @(negedge clk); if (s_ack) seen = 1'b1; end
      check(!seen, "R7 no ack on miss read", 32'(seen), 0);
    end
    d_req = 1'b0;
    repeat (4) @(negedge clk);
    direct = 1'b0;
    prev_req = 1'b0; prev_ack = 1'b0;
    for (int i = 0; i < WORDS; i++) do_op(1'b0, i, '0, 1'b0); // R7 store unchanged

    // random mix
    for (int t = 0; t < 80; t++) begin
      int idx = int'($urandom % WORDS);
      bit we = 1'($urandom);
      do_op(we, idx, DW'($urandom), ($urandom % 5) == 0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule